// File: doc/BRIEF.md
# Serial SAR ADC Read Controller

This block is the host-side master for a single-channel successive-approximation converter that has a three-wire serial port: an active-low chip select, a serial clock and one serial data line back to the host. The converter takes its sample at the instant chip select goes low and converts during that same frame, so the word that comes back belongs to the frame that fetched it. The controller lowers chip select when asked, produces a 16-clock read frame from a divided system clock, shifts the returned bits in and hands the result to the rest of the chip together with a one-cycle strobe.

A frame is requested by a one-cycle start pulse or by a rate tick from a free-running timer. Each returned frame carries four leading zero bits, then the result most significant bit first, then filler bits. The controller checks the leading bits and flags a framing error if any of them is set. After every frame it keeps chip select high for a set number of system clocks. That interval has to cover both the converter's quiet time after its data line floats and its acquisition time. A request that comes while a frame or this interval is still running is held and served as soon as the interval ends.

The serial clock half period (`DIV_HALF`), the high interval between frames (`GAP_CYCLES`) and the result width (`RES_BITS`, at most 12) are parameters.

Top module: `sar_read_ctrl`

## Requirements
- R1: While reset is applied and after it is released, with no request, `adc_cs_n` is 1, `adc_sclk` is 1 and `data_valid` is 0.
- R2: A 1 on `start_req` or `rate_tick` in a cycle where the controller is idle drives `adc_cs_n` to 0 on the next clock edge.
- R3: The first falling edge of `adc_sclk` comes `DIV_HALF` clocks after `adc_cs_n` falls. Every high and low phase of `adc_sclk` inside a frame lasts `DIV_HALF` clocks.
- R4: Each frame has exactly 16 falling edges of `adc_sclk`. `adc_cs_n` and `adc_sclk` both return to 1 `DIV_HALF` clocks after the 16th falling edge.
- R5: `adc_sdata` is sampled at each falling edge of `adc_sclk`, taking the value that was present before that edge, so edge k captures frame bit k-1. Frame bits 4 to 3+`RES_BITS` form `data_out`, most significant bit first, in straight binary.
- R6: For `RES_BITS` below 12, the result is right-aligned in `data_out`. Frame bits after the result field have no effect on any output.
- R7: `frame_err` is 1 with a result exactly when at least one of frame bits 0 to 3 was 1. `data_out` is still delivered in that case.
- R8: `data_valid` is a one-cycle pulse in the cycle in which `adc_cs_n` returns to 1. `data_out` and `frame_err` hold their values until the next pulse.
- R9: After a frame, `adc_cs_n` stays high for at least `GAP_CYCLES` clocks. A request that arrives during the frame or during the interval starts the next frame exactly `GAP_CYCLES` clocks after the rise. A request that comes later starts its frame on the next clock edge.
- R10: Any number of requests that arrive while one frame and its interval are running produce exactly one further frame.
- R11: `adc_sclk` is 1 in every cycle in which `adc_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-shot conversion request |
| rate_tick | input | 1 | Periodic conversion request from a rate timer |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select; its falling edge is the sample instant |
| adc_sclk | output | 1 | Serial clock to the converter, idle high |
| data_out | output | RES_BITS | Last conversion result, right-aligned |
| data_valid | output | 1 | One-cycle strobe for a new result |
| frame_err | output | 1 | Leading-bit check failed for the current result |

## Verification
The interesting collision is a new request landing in the same cycle as the end of the post-frame high interval, or just before or just after it. In those cycles the pending-request logic and the interval timer both decide when chip select may fall. The bench chains frames and moves the request offset after each chip-select rise across every position from the first cycle of the interval to one cycle past its end. For each offset it measures how long chip select stays high and checks the result against the larger of `GAP_CYCLES` and the request offset plus one. A second scenario stacks several requests of both kinds inside one frame and judges that only one extra frame follows.

// File: rtl/srd_pkg.sv
`timescale 1ns/1ps
package srd_pkg;
  // Frame layout fixed by the converter's serial protocol.
  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;
  localparam int MAX_RES    = FRAME_BITS - LEAD_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/srd_interval.sv
`timescale 1ns/1ps
// Wrap-around interval counter: done pulses every LIMIT cycles of run.
module srd_interval #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    if (!run || done) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/srd_shifter.sv
`timescale 1ns/1ps
// Captures the leading bits and the result field, counts every sample.
module srd_shifter
  import srd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         sample_en,
  input  logic                         sdata,
  output logic [LEAD_BITS+RES_BITS-1:0] cap_word,
  output logic [CNT_W-1:0]             bit_cnt
);
  localparam int CAP_W = LEAD_BITS + RES_BITS;
  localparam logic [CNT_W-1:0] CAP_LAST = CNT_W'(CAP_W);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_BITS);

  logic [CAP_W-1:0] word_q, word_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             keep_bit;

  // Bits past the result field are counted but not stored.
  assign keep_bit = sample_en && (cnt_q < CAP_LAST);

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (sample_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (keep_bit) begin
      word_d = {word_q[CAP_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cap_word = word_q;
  assign bit_cnt  = cnt_q;

  AST_NO_EXTRA_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (cnt_q < FRM_LAST)); // R4
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !sample_en); // R5
endmodule

// File: rtl/srd_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer: chip select, serial clock, sample enables, gap and pending request.
module srd_ctrl
  import srd_pkg::*;
#(
  parameter int DIV_HALF   = 2,
  parameter int GAP_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             ph_done,
  input  logic             gap_done,
  input  logic [CNT_W-1:0] bit_cnt,
  output logic             ph_run,
  output logic             gap_run,
  output logic             sample_en,
  output logic             launch,
  output logic             finish,
  output logic             cs_n,
  output logic             sclk
);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_BITS);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int PH_W  = $clog2(DIV_HALF + 1);

  rd_state_e state_q, state_d;
  logic      cs_n_q, cs_n_d;
  logic      sclk_q, sclk_d;
  logic      pend_q, pend_d;
  logic      go;

  assign go      = req || pend_q;
  assign ph_run  = (state_q == ST_SETUP) || (state_q == ST_SHIFT);
  assign gap_run = (state_q == ST_GAP);

  always_comb begin
    state_d   = state_q;
    cs_n_d    = cs_n_q;
    sclk_d    = sclk_q;
    sample_en = 1'b0;
    launch    = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          launch  = 1'b1;
          cs_n_d  = 1'b0;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (ph_done) begin
          sclk_d    = 1'b0;
          sample_en = 1'b1;
          state_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (ph_done) begin
          if (sclk_q) begin
            sclk_d    = 1'b0;
            sample_en = 1'b1;
          end else if (bit_cnt == FRM_LAST) begin
            finish  = 1'b1;
            cs_n_d  = 1'b1;
            sclk_d  = 1'b1;
            state_d = ST_GAP;
          end else begin
            sclk_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gap_done) begin
          if (go) begin
            launch  = 1'b1;
            cs_n_d  = 1'b0;
            state_d = ST_SETUP;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    pend_d = launch ? 1'b0 : (pend_q || req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      pend_q  <= pend_d;
    end
  end

  assign cs_n = cs_n_q;
  assign sclk = sclk_q;

  // Checker state: length of the chip-select high run and of each clock phase.
  logic [GAP_W-1:0] chk_hi_q;
  logic             chk_framed_q;
  logic [PH_W-1:0]  chk_ph_q;
  logic             chk_sclk_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hi_q        <= '0;
      chk_framed_q    <= 1'b0;
      chk_ph_q        <= '0;
      chk_sclk_last_q <= 1'b1;
    end else begin
      if (!cs_n_q) begin
        chk_hi_q <= '0;
      end else if (chk_hi_q != GAP_W'(GAP_CYCLES)) begin
        chk_hi_q <= chk_hi_q + 1'b1;
      end
      if (finish) begin
        chk_framed_q <= 1'b1;
      end
      if (sclk_q != chk_sclk_last_q) begin
        chk_ph_q <= PH_W'(1);
      end else if (chk_ph_q != PH_W'(DIV_HALF)) begin
        chk_ph_q <= chk_ph_q + 1'b1;
      end
      chk_sclk_last_q <= sclk_q;
    end
  end

  AST_IDLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req) |=> !cs_n_q); // R2
  AST_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q != chk_sclk_last_q) |-> (chk_ph_q >= PH_W'(DIV_HALF))); // R3
  AST_SIXTEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (bit_cnt == FRM_LAST)); // R4
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_q) && chk_framed_q) |-> (chk_hi_q >= GAP_W'(GAP_CYCLES))); // R9
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sclk_q); // R11
endmodule

// File: rtl/sar_read_ctrl.sv
`timescale 1ns/1ps
module sar_read_ctrl
  import srd_pkg::*;
#(
  parameter int DIV_HALF   = 2,
  parameter int GAP_CYCLES = 6,
  parameter int RES_BITS   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                rate_tick,
  input  logic                adc_sdata,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic [RES_BITS-1:0] data_out,
  output logic                data_valid,
  output logic                frame_err
);
  localparam int CAP_W = LEAD_BITS + RES_BITS;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic             req;
  logic             ph_run, gap_run, ph_done, gap_done;
  logic             sample_en, launch, finish;
  logic [CAP_W-1:0] cap_word;
  logic [CNT_W-1:0] bit_cnt;

  assign req = start_req || rate_tick;

  srd_interval #(.LIMIT(DIV_HALF)) u_phase (
    .clk  (clk),
    .rst_n(rst_core_n),
    .run  (ph_run),
    .done (ph_done)
  );

  srd_interval #(.LIMIT(GAP_CYCLES)) u_gap (
    .clk  (clk),
    .rst_n(rst_core_n),
    .run  (gap_run),
    .done (gap_done)
  );

  srd_shifter #(.RES_BITS(RES_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clear    (launch),
    .sample_en(sample_en),
    .sdata    (adc_sdata),
    .cap_word (cap_word),
    .bit_cnt  (bit_cnt)
  );

  srd_ctrl #(.DIV_HALF(DIV_HALF), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req      (req),
    .ph_done  (ph_done),
    .gap_done (gap_done),
    .bit_cnt  (bit_cnt),
    .ph_run   (ph_run),
    .gap_run  (gap_run),
    .sample_en(sample_en),
    .launch   (launch),
    .finish   (finish),
    .cs_n     (adc_cs_n),
    .sclk     (adc_sclk)
  );

  // Result register, loaded on the edge that raises chip select.
  logic [RES_BITS-1:0] data_q, data_d;
  logic                err_q, err_d;
  logic                vld_q;

  always_comb begin
    data_d = data_q;
    err_d  = err_q;
    if (finish) begin
      data_d = cap_word[RES_BITS-1:0];
      err_d  = |cap_word[CAP_W-1 -: LEAD_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      err_q  <= err_d;
      vld_q  <= finish;
    end
  end

  assign data_out   = data_q;
  assign frame_err  = err_q;
  assign data_valid = vld_q;

  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_core_n)
    data_valid |-> $rose(adc_cs_n)); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    data_valid |=> !data_valid); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !data_valid |-> ($stable(data_out) && $stable(frame_err))); // R8
endmodule

// File: tb/sar_read_ctrl_test.sv
`timescale 1ns/1ps
// Behavioural converter: first bit at chip-select fall, next bit after each clock fall.
module srd_adc_model (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [15:0] frame_word,
  output logic        sdata
);
  logic [15:0] sh;
  initial begin
    sh    = '0;
    sdata = 1'b0;
  end
  always @(negedge cs_n) begin
    sh = frame_word;
    sdata <= #1 sh[15];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      sh = {sh[14:0], 1'b0};
      sdata <= #1 sh[15];
    end
  end
endmodule

module sar_read_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int GAP  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic rate_tick = 1'b0;
  logic [15:0] word_a = '0;
  logic [15:0] word_b = '0;
  logic sdata_a, sdata_b;
  logic cs_a, sclk_a, valid_a, err_a;
  logic cs_b, sclk_b, valid_b, err_b;
  logic [11:0] data_a;
  logic [7:0]  data_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_read_ctrl #(.DIV_HALF(DIV), .GAP_CYCLES(GAP), .RES_BITS(12)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rate_tick(rate_tick),
    .adc_sdata(sdata_a), .adc_cs_n(cs_a), .adc_sclk(sclk_a),
    .data_out(data_a), .data_valid(valid_a), .frame_err(err_a));

  sar_read_ctrl #(.DIV_HALF(DIV), .GAP_CYCLES(GAP), .RES_BITS(8)) uut_b (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rate_tick(rate_tick),
    .adc_sdata(sdata_b), .adc_cs_n(cs_b), .adc_sclk(sclk_b),
    .data_out(data_b), .data_valid(valid_b), .frame_err(err_b));

  srd_adc_model m_a (.cs_n(cs_a), .sclk(sclk_a), .frame_word(word_a), .sdata(sdata_a));
  srd_adc_model m_b (.cs_n(cs_b), .sclk(sclk_b), .frame_word(word_b), .sdata(sdata_b));

  // Port monitor for uut, sampled on the falling system clock edge.
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int hi_run = 0, gap_rec = 0, falls = 0, last_falls = 0;
  int low_cnt = 0, setup_rec = 0, run_len = 0;
  int phase_viol = 0, idle_viol = 0, frames_started = 0;
  bit first_fall = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !cs_a) begin
      gap_rec = hi_run; hi_run = 0; frames_started++;
      falls = 0; low_cnt = 1; first_fall = 1'b0; run_len = 1;
    end else if (!cs_a) begin
      if (prev_sclk && !sclk_a) begin
        falls++;
        if (!first_fall) begin setup_rec = low_cnt; first_fall = 1'b1; end
      end
      if (sclk_a != prev_sclk) begin
        if (run_len < DIV) phase_viol++;
        run_len = 1;
      end else begin
        run_len++;
      end
      low_cnt++;
    end
    if (!prev_cs && cs_a) begin last_falls = falls; hi_run = 1; end
    else if (cs_a) hi_run++;
    if (cs_a && !sclk_a) idle_viol++;
    prev_cs = cs_a; prev_sclk = sclk_a;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (valid_a) begin ok = 1'b1; break; end
    end
    #1;
    if (!ok) chk(1'b0, "R4", "result strobe timeout", 0, 1);
  endtask

  task automatic pulse_req(input bit use_tick);
    if (use_tick) rate_tick = 1'b1; else start_req = 1'b1;
    @(negedge clk);
    rate_tick = 1'b0; start_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_a == 1'b1, "R1", "cs_n in reset", cs_a, 1);
    chk(sclk_a == 1'b1, "R1", "sclk in reset", sclk_a, 1);
    chk(valid_a == 1'b0, "R1", "valid in reset", valid_a, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_a == 1'b1 && sclk_a == 1'b1 && valid_a == 1'b0, "R1",
        "idle outputs after reset", {cs_a, sclk_a, valid_a}, 3'b110);
  endtask

  // One frame from idle, all results and timings checked.
  task automatic t_frame(input logic [15:0] wa, input logic [15:0] wb, input bit use_tick,
                         input int exp_a, input bit exp_err, input int exp_b, input bit exp_err_b);
    bit ok;
    word_a = wa; word_b = wb;
    pulse_req(use_tick);
    chk(cs_a == 1'b0, "R2", "cs_n one clock after request", cs_a, 0);
    wait_valid(ok);
    chk(int'(data_a) == exp_a, "R5", "12-bit result", data_a, exp_a);
    chk(err_a == exp_err, "R7", "frame_err 12-bit", err_a, exp_err);
    chk(int'(data_b) == exp_b, "R6", "8-bit right-aligned result", data_b, exp_b);
    chk(err_b == exp_err_b, "R7", "frame_err 8-bit", err_b, exp_err_b);
    chk(last_falls == 16, "R4", "sclk falls per frame", last_falls, 16);
    chk(setup_rec == DIV, "R3", "cs low to first sclk fall", setup_rec, DIV);
    chk(phase_viol == 0, "R3", "short sclk phase", phase_viol, 0);
    chk(cs_a == 1'b1 && sclk_a == 1'b1, "R4", "cs and sclk high with strobe",
        {cs_a, sclk_a}, 2'b11);
    @(negedge clk);
    chk(valid_a == 1'b0, "R8", "strobe one cycle wide", valid_a, 0);
    repeat (GAP + 2) @(negedge clk);
  endtask

  task automatic t_hold();
    logic [11:0] held;
    bit stable = 1'b1;
    held = data_a;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (data_a != held || valid_a || !cs_a) stable = 1'b0;
    end
    chk(stable, "R8", "result held while idle", data_a, held);
  endtask

  // Request offset swept across the post-frame interval.
  task automatic t_gap_sweep();
    bit ok;
    int exp_gap;
    word_a = 16'h0123; word_b = 16'h0450;
    pulse_req(1'b0);
    wait_valid(ok);
    for (int off = 0; off <= GAP + 1; off++) begin
      for (int k = 0; k < off; k++) @(negedge clk);
      word_a = 16'(off * 16'h0111); word_b = {4'h0, 8'(off * 8'h13), 4'hF};
      pulse_req(off[0]);
      wait_valid(ok);
      exp_gap = (off + 1 > GAP) ? off + 1 : GAP;
      chk(gap_rec == exp_gap, "R9", $sformatf("cs high run, offset %0d", off), gap_rec, exp_gap);
      chk(int'(data_a) == (off * 'h111) % 4096, "R5", "result in sweep", data_a, (off * 'h111) % 4096);
      chk(int'(data_b) == (off * 'h13) % 256, "R6", "trailing bits ignored", data_b, (off * 'h13) % 256);
    end
    repeat (GAP + 2) @(negedge clk);
  endtask

  // Several requests stacked inside one frame.
  task automatic t_pending();
    bit ok;
    int base;
    base = frames_started;
    word_a = 16'h0A5A; word_b = 16'h03C0;
    pulse_req(1'b0);
    repeat (8) @(negedge clk);
    pulse_req(1'b0);
    repeat (8) @(negedge clk);
    pulse_req(1'b1);
    repeat (8) @(negedge clk);
    pulse_req(1'b0);
    wait_valid(ok);
    wait_valid(ok);
    chk(gap_rec == GAP, "R9", "pending request starts at interval end", gap_rec, GAP);
    chk(int'(data_a) == 'hA5A, "R5", "result of pending frame", data_a, 'hA5A);
    repeat (80) @(negedge clk);
    chk(frames_started - base == 2, "R10", "frames from stacked requests",
        frames_started - base, 2);
    chk(cs_a == 1'b1, "R10", "idle after collapsed requests", cs_a, 1);
  endtask

  initial begin
    t_reset();
    t_frame(16'h0ABC, 16'h0A76, 1'b0, 'hABC, 1'b0, 'hA7, 1'b0);
    t_frame(16'h0000, 16'h000F, 1'b1, 'h000, 1'b0, 'h00, 1'b0);
    t_frame(16'h0FFF, 16'h0FF0, 1'b0, 'hFFF, 1'b0, 'hFF, 1'b0);
    t_frame(16'h8123, 16'h25AF, 1'b1, 'h123, 1'b1, 'h5A, 1'b1);
    t_hold();
    t_frame(16'h0456, 16'h0C30, 1'b0, 'h456, 1'b0, 'hC3, 1'b0);
    t_gap_sweep();
    t_pending();
    chk(idle_viol == 0, "R11", "sclk low while cs_n high", idle_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule